// File: doc/BRIEF.md
# Four-Mode Square-Wave and Pulse Timer

This block is a down-counting interval timer. It takes a terminal count and a two-bit mode code and produces one output waveform, timed by its input clock. A single strobe both loads the settings and starts the timer. The mode code selects the shape of the output, square wave or narrow pulse, and whether the timer runs once or repeats. A busy flag shows while a waveform is in progress.

In the square-wave modes a period is split into a high part and a low part. For an odd count the high part is one clock longer than the low part. In the pulse modes the output drops low for one clock at the end of each period. The output rests high whenever the timer is idle. A strobe that arrives while a waveform is running abandons that waveform and starts again at once with the new settings.

Top module: `sqp_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `tmr_out_o` is 1 and `busy_o` is 0.
- R2: A rising clock edge with `load_i` high captures `tc_i` and `mode_i`. From the next cycle `busy_o` is 1 and `tmr_out_o` is 1. That cycle is clock 1 of the first period.
- R3: Mode code 2'b00 gives one square-wave period of TC clocks. The output is high for clocks 1 to ceil(TC/2) and low for the remaining floor(TC/2) clocks. At clock TC+1 the output is 1 and `busy_o` is 0.
- R4: Mode code 2'b01 gives square-wave periods of TC clocks back to back, with the same high/low split as R3. It reloads without a gap and `busy_o` stays 1.
- R5: For an odd TC the high part is (TC+1)/2 clocks and the low part is (TC-1)/2 clocks. For an even TC both parts are TC/2 clocks.
- R6: Mode code 2'b10 holds the output high and drives it low only during clock TC. At clock TC+1 the output is 1 and `busy_o` is 0.
- R7: Mode code 2'b11 drives the output low for exactly one clock, on clock TC of every period of TC clocks, and keeps repeating.
- R8: A load strobe while `busy_o` is 1 abandons the current period and restarts from clock 1 with the new count and mode.
- R9: A `tc_i` value of 0 or 1 behaves exactly as a value of 2.
- R10: Whenever `busy_o` is 0 the output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load-and-start strobe |
| tc_i | input | CNT_W (14) | Terminal count, captured on load |
| mode_i | input | 2 | Mode code, captured on load |
| tmr_out_o | output | 1 | Timer output waveform |
| busy_o | output | 1 | High while a waveform is in progress |

## Verification
The bench compares the output with a cycle model at every clock. It uses odd and even counts, so a design that split an odd period evenly, or put the extra clock in the low part, would show the edge one clock off. It drives counts of 0 and 1, where a design without clamping would stall or run for 2^14 clocks. It loads a new setting in the middle of a period, where a design that kept the old phase would place the next pulse wrongly. It also checks the maximum count for wrap errors, and applies reset in the middle of a run to confirm that the timer stops and the output returns high.

// File: rtl/sqp_timer_pkg.sv
package sqp_timer_pkg;

    typedef enum logic [1:0] {
        MODE_SQ_ONCE = 2'b00,
        MODE_SQ_RPT  = 2'b01,
        MODE_PL_ONCE = 2'b10,
        MODE_PL_RPT  = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic repeat_en;
        logic pulse_en;
    } tmr_kind_t;

    localparam int unsigned TC_FLOOR = 2;

    function automatic tmr_kind_t decode_mode(input logic [1:0] m);
        tmr_kind_t k;
        k.repeat_en = m[0];
        k.pulse_en  = m[1];
        return k;
    endfunction

    function automatic int unsigned clamp_tc(input int unsigned t);
        return (t < TC_FLOOR) ? TC_FLOOR : t;
    endfunction

    function automatic int unsigned high_len(input int unsigned t);
        return (t + 1) / 2;
    endfunction

endpackage

// File: rtl/sqp_cfg_reg.sv
module sqp_cfg_reg
    import sqp_timer_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] tc_i,
    input  logic [1:0]       mode_i,
    output logic [CNT_W-1:0] tc_q,
    output logic [CNT_W-1:0] hi_q,
    output tmr_kind_t        kind_q
);
    logic [CNT_W-1:0] tc_eff;
    logic [CNT_W-1:0] hi_eff;
    int unsigned      tc_int;

    always_comb begin
        tc_int = clamp_tc(32'(tc_i));
        tc_eff = tc_int[CNT_W-1:0];
        hi_eff = CNT_W'(high_len(tc_int));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_q   <= CNT_W'(TC_FLOOR);
            hi_q   <= CNT_W'(1);
            kind_q <= '0;
        end else if (load_i) begin
            tc_q   <= tc_eff;
            hi_q   <= hi_eff;
            kind_q <= decode_mode(mode_i);
        end
    end
endmodule

// File: rtl/sqp_phase_ctr.sv
module sqp_phase_ctr #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] tc_q,
    input  logic             repeat_en,
    output logic [CNT_W-1:0] phase_nxt,
    output logic             run_nxt,
    output logic             run_q
);
    logic [CNT_W-1:0] phase_q;
    logic             at_end;

    assign at_end = (phase_q == tc_q - CNT_W'(1));

    always_comb begin
        phase_nxt = phase_q;
        run_nxt   = run_q;
        if (load_i) begin
            phase_nxt = '0;
            run_nxt   = 1'b1;
        end else if (run_q) begin
            if (at_end) begin
                phase_nxt = '0;
                run_nxt   = repeat_en;
            end else begin
                phase_nxt = phase_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            run_q   <= 1'b0;
        end else begin
            phase_q <= phase_nxt;
            run_q   <= run_nxt;
        end
    end
endmodule

// File: rtl/sqp_wave_gen.sv
module sqp_wave_gen #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             run_nxt,
    input  logic [CNT_W-1:0] phase_nxt,
    input  logic [CNT_W-1:0] tc_q,
    input  logic [CNT_W-1:0] hi_q,
    input  logic             pulse_en,
    output logic             out_q
);
    logic out_d;

    always_comb begin
        if (load_i || !run_nxt) begin
            out_d = 1'b1;
        end else if (pulse_en) begin
            out_d = (phase_nxt != tc_q - CNT_W'(1));
        end else begin
            out_d = (phase_nxt < hi_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b1;
        else     out_q <= out_d;
    end
endmodule

// File: rtl/sqp_timer.sv
module sqp_timer
    import sqp_timer_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] tc_i,
    input  logic [1:0]       mode_i,
    output logic             tmr_out_o,
    output logic             busy_o
);
    logic [CNT_W-1:0] tc_q;
    logic [CNT_W-1:0] hi_q;
    tmr_kind_t        kind_q;
    logic [CNT_W-1:0] phase_nxt;
    logic             run_nxt;
    logic             run_q;

    sqp_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .tc_i   (tc_i),
        .mode_i (mode_i),
        .tc_q   (tc_q),
        .hi_q   (hi_q),
        .kind_q (kind_q)
    );

    sqp_phase_ctr #(.CNT_W(CNT_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .tc_q      (tc_q),
        .repeat_en (kind_q.repeat_en),
        .phase_nxt (phase_nxt),
        .run_nxt   (run_nxt),
        .run_q     (run_q)
    );

    sqp_wave_gen #(.CNT_W(CNT_W)) u_wave (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .run_nxt   (run_nxt),
        .phase_nxt (phase_nxt),
        .tc_q      (tc_q),
        .hi_q      (hi_q),
        .pulse_en  (kind_q.pulse_en),
        .out_q     (tmr_out_o)
    );

    assign busy_o = run_q;
endmodule

// File: rtl/sqp_timer_chk.sv
module sqp_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       load_i,
    input logic [1:0] mode_i,
    input logic       tmr_out_o,
    input logic       busy_o
);
    logic [1:0] mode_seen;
    logic       seen_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_seen <= 2'b00;
            seen_load <= 1'b0;
        end else if (load_i) begin
            mode_seen <= mode_i;
            seen_load <= 1'b1;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (tmr_out_o && !busy_o)); // R1

    AST_LOAD_START: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (busy_o && tmr_out_o)); // R2

    AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        (seen_load && mode_seen[1] && !tmr_out_o) |=> tmr_out_o); // R7

    AST_REPEAT_KEEPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (seen_load && mode_seen[0] && busy_o) |=> busy_o); // R4

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> tmr_out_o); // R10
endmodule

bind sqp_timer sqp_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_i),
    .mode_i    (mode_i),
    .tmr_out_o (tmr_out_o),
    .busy_o    (busy_o)
);

// File: tb/sqp_timer_bench.sv
module sqp_timer_bench;
    localparam int CNT_W = 14;

    logic             clk = 1'b0;
    logic             rst;
    logic             load_i;
    logic [CNT_W-1:0] tc_i;
    logic [1:0]       mode_i;
    logic             tmr_out_o;
    logic             busy_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    sqp_timer #(.CNT_W(CNT_W)) u_sqp_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .tc_i      (tc_i),
        .mode_i    (mode_i),
        .tmr_out_o (tmr_out_o),
        .busy_o    (busy_o)
    );

    always #2.5 clk = ~clk;

    task automatic check2(input string req, input logic act_o, input logic act_b,
                          input logic exp_o, input logic exp_b, input int cyc);
        n_checks++;
        if (act_o !== exp_o || act_b !== exp_b) begin
            n_errors++;
            $display("FAIL %s clk %0d: out=%b busy=%b expected out=%b busy=%b",
                     req, cyc, act_o, act_b, exp_o, exp_b);
        end
    endtask

    // n counts clocks after the load edge: n=0 is clock 1 of the first period
    task automatic model(input int mode, input int tc, input int n,
                         output logic eo, output logic eb);
        int tce = (tc < 2) ? 2 : tc;
        int hi  = (tce + 1) / 2;
        int p   = n % tce;
        if ((mode % 2 == 0) && n >= tce) begin
            eo = 1'b1; eb = 1'b0;
        end else begin
            eb = 1'b1;
            if (mode >= 2) eo = (p != tce - 1);
            else           eo = (p < hi);
        end
    endtask

    task automatic run_case(input string req, input int mode, input int tc, input int ncyc);
        logic eo, eb;
        @(negedge clk);
        load_i = 1'b1;
        tc_i   = CNT_W'(tc);
        mode_i = 2'(mode);
        @(negedge clk);
        load_i = 1'b0;
        for (int n = 0; n < ncyc; n++) begin
            model(mode, tc, n, eo, eb);
            check2(req, tmr_out_o, busy_o, eo, eb, n);
            if (n != ncyc - 1) @(negedge clk);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1; load_i = 1'b0; tc_i = '0; mode_i = 2'b00;
        repeat (3) @(negedge clk);
        check2("R1", tmr_out_o, busy_o, 1'b1, 1'b0, 0);
        rst = 1'b0;
        @(negedge clk);
        check2("R1", tmr_out_o, busy_o, 1'b1, 1'b0, 1);
    endtask

    task automatic test_reset_midrun();
        run_case("R4", 1, 9, 6);
        rst = 1'b1;
        @(negedge clk);
        check2("R1", tmr_out_o, busy_o, 1'b1, 1'b0, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check2("R10", tmr_out_o, busy_o, 1'b1, 1'b0, 1);
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: out=%b busy=%b expected run to complete", tmr_out_o, busy_o);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        test_reset();
        run_case("R2", 0, 6, 2);
        run_case("R3", 0, 6, 10);
        run_case("R5", 0, 7, 11);
        run_case("R5", 1, 5, 16);
        run_case("R4", 1, 8, 20);
        run_case("R6", 2, 4, 8);
        run_case("R7", 3, 3, 12);
        run_case("R9", 3, 1, 8);
        run_case("R9", 0, 0, 5);
        run_case("R9", 1, 1, 6);
        run_case("R8", 1, 10, 3);
        run_case("R8", 2, 5, 8);
        run_case("R8", 3, 6, 4);
        run_case("R8", 0, 3, 6);
        run_case("R10", 2, 2, 5);
        run_case("R3", 0, 16383, 16386);
        test_reset_midrun();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule